// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a synchronous content-addressable memory built from flip-flops. By default it has 512 entries of 64 bits. One command port carries an operation code, an entry address and a data word. Five operations are decoded:
- write an entry, which also marks it valid;
- read an entry, which returns its data and its valid bit;
- invalidate an entry;
- load the global compare mask;
- search.

A search compares the supplied word against every valid entry in parallel. Bit positions whose mask bit is zero are left out of the comparison. A priority encoder turns the per-entry match vector into one result: a hit flag, the index of the lowest matching entry, and a flag that says whether more than one entry matched.

All results are registered. A read or search issued in one cycle is answered in the next cycle. Search results hold until the next search.

Top module: `masked_cam`

## Requirements
- R1: After reset, every entry is invalid and the compare mask is all ones, so every bit position is compared. Reset does not clear the entry data.
- R2: The write operation (code 1) stores `cmd_data` at `cmd_addr` and sets that entry's valid bit. The read operation (code 2) makes `rd_valid` high for exactly the one cycle after the command, with `rd_data` holding the entry data and `rd_entry_valid` holding its valid bit.
- R3: The load-mask operation (code 4) copies `cmd_data` into the mask. In a search (code 5), an entry matches when it agrees with `cmd_data` at every position where the mask bit is 1. Positions where the mask bit is 0 are ignored.
- R4: An invalid entry never matches. The invalidate operation (code 3) clears the valid bit of the entry at `cmd_addr` and leaves its data unchanged.
- R5: When two or more entries match, `srch_index` reports the lowest matching index and `srch_multi` is 1. When exactly one entry matches, `srch_multi` is 0.
- R6: When no valid entry matches, `srch_hit`, `srch_multi` and `srch_index` are all 0.
- R7: `srch_done` is high for exactly the one cycle after a search command. The search outputs then hold their values until the next search.
- R8: A write issued in one cycle is visible to a search issued in the following cycle.
- R9: A command with `cmd_valid` low, with operation code 0 (no operation), or with an unused code (6 or 7) changes no entry, valid bit or mask, and produces no read or search response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Operation code: 0 none, 1 write, 2 read, 3 invalidate, 4 load mask, 5 search |
| cmd_addr | input | 9 | Entry address for write, read and invalidate |
| cmd_data | input | 64 | Write data, mask value or search word |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Data of the entry that was read |
| rd_entry_valid | output | 1 | Valid bit of the entry that was read |
| srch_done | output | 1 | Search response strobe |
| srch_hit | output | 1 | At least one valid entry matched |
| srch_multi | output | 1 | Two or more valid entries matched |
| srch_index | output | 9 | Lowest matching index, 0 on a miss |

## Verification
The assertions check the following on every clock cycle:
- the valid-bit and mask updates caused by write, invalidate and load-mask commands;
- that the encoded index always points at a set match bit with no set bit below it;
- the consistency of hit, multi and index, the one-cycle search strobe, and that results hold between searches.

Some behaviours can only be shown by the bench's scenarios:
- that masked-out positions really are ignored;
- that duplicate entries resolve to the lowest index;
- that the top index 511 is reachable;
- that invalidation moves the winner to the next matching entry;
- that ignored commands leave the state untouched.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_WRITE  = 3'd1,
      OP_READ   = 3'd2,
      OP_INVAL  = 3'd3,
      OP_MASK   = 3'd4,
      OP_SEARCH = 3'd5
   } cam_op_e;
endpackage

// File: rtl/cam_store.sv
module cam_store import cam_pkg::*; #(
   parameter int ENTRIES = 512,
   parameter int WIDTH   = 64,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cmd_valid,
   input  logic [2:0]                      cmd_op,
   input  logic [AW-1:0]                   cmd_addr,
   input  logic [WIDTH-1:0]                cmd_data,
   output logic [ENTRIES-1:0][WIDTH-1:0]   words,
   output logic [ENTRIES-1:0]              valids,
   output logic [WIDTH-1:0]                mask,
   output logic                            rd_valid,
   output logic [WIDTH-1:0]                rd_data,
   output logic                            rd_entry_valid
);
   logic [ENTRIES-1:0][WIDTH-1:0] word_q;
   logic [ENTRIES-1:0]            valid_q;
   logic [WIDTH-1:0]              mask_q;
   logic                          do_wr, do_rd, do_inv, do_mask;

   assign do_wr   = cmd_valid && (cmd_op == OP_WRITE);
   assign do_rd   = cmd_valid && (cmd_op == OP_READ);
   assign do_inv  = cmd_valid && (cmd_op == OP_INVAL);
   assign do_mask = cmd_valid && (cmd_op == OP_MASK);

   // entry data has no reset: it is only meaningful while its valid bit is set
   always_ff @(posedge clk) begin
      if (do_wr) word_q[cmd_addr] <= cmd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         mask_q  <= '1;
      end else begin
         if (do_wr)   valid_q[cmd_addr] <= 1'b1;
         if (do_inv)  valid_q[cmd_addr] <= 1'b0;
         if (do_mask) mask_q <= cmd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid       <= 1'b0;
         rd_data        <= '0;
         rd_entry_valid <= 1'b0;
      end else begin
         rd_valid <= do_rd;
         if (do_rd) begin
            rd_data        <= word_q[cmd_addr];
            rd_entry_valid <= valid_q[cmd_addr];
         end
      end
   end

   assign words  = word_q;
   assign valids = valid_q;
   assign mask   = mask_q;

   assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |=> valid_q[$past(cmd_addr)]);
   assert_inval_clears_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      do_inv |=> !valid_q[$past(cmd_addr)]);
   assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      do_mask |=> (mask_q == $past(cmd_data)));
   assert_idle_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_wr || do_inv || do_mask) |=> ($stable(valid_q) && $stable(mask_q)));
endmodule

// File: rtl/cam_match.sv
module cam_match #(
   parameter int ENTRIES = 512,
   parameter int WIDTH   = 64
) (
   input  logic [ENTRIES-1:0][WIDTH-1:0] words,
   input  logic [ENTRIES-1:0]            valids,
   input  logic [WIDTH-1:0]              mask,
   input  logic [WIDTH-1:0]              key,
   output logic [ENTRIES-1:0]            match
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_line
      assign match[i] = valids[i] && (((words[i] ^ key) & mask) == '0);
   end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
   parameter int ENTRIES = 512,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] match,
   output logic               any,
   output logic               multi,
   output logic [AW-1:0]      idx
);
   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) idx = AW'(i);
      end
   end

   assign any   = |match;
   assign multi = |(match & (match - 1'b1));
endmodule

// File: rtl/masked_cam.sv
module masked_cam import cam_pkg::*; #(
   parameter int ENTRIES = 512,
   parameter int WIDTH   = 64,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [WIDTH-1:0] cmd_data,
   output logic             rd_valid,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_entry_valid,
   output logic             srch_done,
   output logic             srch_hit,
   output logic             srch_multi,
   output logic [AW-1:0]    srch_index
);
   if (ENTRIES < 2 || ENTRIES != (1 << AW)) begin : g_bad_entries
      $error("masked_cam: ENTRIES must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("masked_cam: WIDTH must be positive");
   end

   logic [ENTRIES-1:0][WIDTH-1:0] words;
   logic [ENTRIES-1:0]            valids;
   logic [WIDTH-1:0]              mask;
   logic [ENTRIES-1:0]            match_vec;
   logic                          enc_any, enc_multi;
   logic [AW-1:0]                 enc_idx;
   logic                          do_search;

   assign do_search = cmd_valid && (cmd_op == OP_SEARCH);

   cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .words(words), .valids(valids),
      .mask(mask), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_entry_valid(rd_entry_valid)
   );

   cam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
      .words(words), .valids(valids), .mask(mask), .key(cmd_data), .match(match_vec)
   );

   cam_prio #(.ENTRIES(ENTRIES)) u_prio (
      .match(match_vec), .any(enc_any), .multi(enc_multi), .idx(enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srch_done  <= 1'b0;
         srch_hit   <= 1'b0;
         srch_multi <= 1'b0;
         srch_index <= '0;
      end else begin
         srch_done <= do_search;
         if (do_search) begin
            srch_hit   <= enc_any;
            srch_multi <= enc_multi;
            srch_index <= enc_idx;
         end
      end
   end

   assert_index_points_at_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      enc_any |-> match_vec[enc_idx]);
   assert_no_lower_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      enc_any |-> ((match_vec << (ENTRIES - int'(enc_idx))) == '0));
   assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_hit |-> (srch_index == '0 && !srch_multi));
   assert_multi_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      srch_multi |-> srch_hit);
   assert_done_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      do_search |=> srch_done);
   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !do_search |=> (!srch_done && $stable(srch_hit) && $stable(srch_index)));
endmodule

// File: tb/tb_masked_cam.sv
module tb_masked_cam;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [8:0]  cmd_addr = '0;
   logic [63:0] cmd_data = '0;
   logic        rd_valid, rd_entry_valid, srch_done, srch_hit, srch_multi;
   logic [63:0] rd_data;
   logic [8:0]  srch_index;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   masked_cam dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_entry_valid(rd_entry_valid), .srch_done(srch_done),
      .srch_hit(srch_hit), .srch_multi(srch_multi), .srch_index(srch_index)
   );

   typedef struct packed {
      logic [63:0] mask;
      logic [63:0] key;
      logic        hit;
      logic        multi;
      logic [8:0]  idx;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444, 1'b1, 1'b1, 9'd5},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_A5A5_A5A5_A5A5, 1'b1, 1'b0, 9'd511},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_00FF, 1'b1, 1'b0, 9'd20},
      '{64'hFFFF_FFFF_0000_FFFF, 64'hDEAD_BEEF_FFFF_00FF, 1'b1, 1'b1, 9'd20},
      '{64'hFFFF_FFFF_FFFF_0000, 64'hDEAD_BEEF_1234_0000, 1'b1, 1'b0, 9'd300},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0, 1'b0, 9'd0},
      '{64'h0000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 9'd5}
   };

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one command for one cycle; outputs are sampled at the following negedge
   task automatic do_cmd(input logic [2:0] op, input logic [8:0] addr,
                         input logic [63:0] data);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic search_expect(input logic [63:0] key, input logic hit,
                                input logic multi, input logic [8:0] idx,
                                input string req);
      do_cmd(3'd5, '0, key);
      check(srch_done == 1'b1, {req, " done"}, 64'(srch_done), 64'd1);
      check(srch_hit == hit, {req, " hit"}, 64'(srch_hit), 64'(hit));
      check(srch_multi == multi, {req, " multi"}, 64'(srch_multi), 64'(multi));
      check(srch_index == idx, {req, " index"}, 64'(srch_index), 64'(idx));
   endtask

   task automatic read_expect(input logic [8:0] addr, input logic vld,
                              input logic [63:0] data, input bit chk_data,
                              input string req);
      do_cmd(3'd2, addr, '0);
      check(rd_valid == 1'b1, {req, " rd_valid"}, 64'(rd_valid), 64'd1);
      check(rd_entry_valid == vld, {req, " entry valid"}, 64'(rd_entry_valid), 64'(vld));
      if (chk_data) check(rd_data == data, {req, " data"}, rd_data, data);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check(srch_hit == 1'b0 && srch_done == 1'b0 && rd_valid == 1'b0, "R1 outputs idle",
            64'({srch_hit, srch_done, rd_valid}), 64'd0);
      read_expect(9'd0, 1'b0, '0, 1'b0, "R1 entry 0 invalid");
      read_expect(9'd511, 1'b0, '0, 1'b0, "R1 entry 511 invalid");
      search_expect('0, 1'b0, 1'b0, 9'd0, "R1 empty array misses");

      // R2: write and read back
      do_cmd(3'd1, 9'd5, 64'h1111_2222_3333_4444);
      read_expect(9'd5, 1'b1, 64'h1111_2222_3333_4444, 1'b1, "R2 readback");
      @(negedge clk);
      check(rd_valid == 1'b0, "R2 rd_valid one cycle", 64'(rd_valid), 64'd0);

      // R1: mask is all ones after reset, a single differing bit misses
      search_expect(64'h1111_2222_3333_4445, 1'b0, 1'b0, 9'd0, "R1 mask all ones");

      do_cmd(3'd1, 9'd9,   64'h1111_2222_3333_4444);
      do_cmd(3'd1, 9'd20,  64'hDEAD_BEEF_0000_00FF);
      do_cmd(3'd1, 9'd511, 64'hA5A5_A5A5_A5A5_A5A5);
      do_cmd(3'd1, 9'd300, 64'hDEAD_BEEF_1234_00FF);

      // table of masked searches: R3, R5, R6
      for (int i = 0; i < NVEC; i++) begin
         do_cmd(3'd4, '0, VEC[i].mask);
         search_expect(VEC[i].key, VEC[i].hit, VEC[i].multi, VEC[i].idx,
                       $sformatf("R3/R5/R6 vector %0d", i));
      end

      // R7: results hold, strobe low, across idle cycles
      repeat (3) @(negedge clk);
      check(srch_done == 1'b0, "R7 done low when idle", 64'(srch_done), 64'd0);
      check(srch_hit == 1'b1 && srch_index == 9'd5, "R7 result held",
            64'(srch_index), 64'd5);

      // R4: invalidation moves the winner and keeps the data
      do_cmd(3'd4, '0, ONES);
      do_cmd(3'd3, 9'd5, '0);
      search_expect(64'h1111_2222_3333_4444, 1'b1, 1'b0, 9'd9, "R4 next winner");
      read_expect(9'd5, 1'b0, 64'h1111_2222_3333_4444, 1'b1, "R4 data kept");
      do_cmd(3'd3, 9'd9, '0);
      search_expect(64'h1111_2222_3333_4444, 1'b0, 1'b0, 9'd0, "R4 R6 all invalid");

      // R8: write followed at once by a search
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 9'd40; cmd_data = 64'h0BAD_F00D_CAFE_0040;
      @(negedge clk);
      cmd_op = 3'd5;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
      check(srch_hit == 1'b1 && srch_index == 9'd40, "R8 back-to-back write",
            64'(srch_index), 64'd40);

      // R9: ignored commands
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd1; cmd_addr = 9'd1; cmd_data = ONES;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd6; cmd_addr = 9'd2;
      @(negedge clk);
      cmd_op = 3'd0; cmd_addr = 9'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(srch_done == 1'b0 && rd_valid == 1'b0, "R9 no response",
            64'({srch_done, rd_valid}), 64'd0);
      read_expect(9'd1, 1'b0, '0, 1'b0, "R9 valid low ignored");
      read_expect(9'd2, 1'b0, '0, 1'b0, "R9 unused code ignored");
      search_expect(64'h0BAD_F00D_CAFE_0040, 1'b1, 1'b0, 9'd40, "R9 mask unchanged");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule